// File: doc/BRIEF.md
# Paged DMA Address Translator

This block is the channel side of a DMA engine that reaches system memory through a page table held in that same memory. A device asks for a transfer by giving a channel number, a byte length and a direction. The engine first makes sure the channel is in a state that permits the transfer. It then limits the length to what the channel still has left. It then walks the transfer one page segment at a time. For each segment it reads a table entry from memory, adds the page offset to the frame held in that entry, and issues the data move on a simple request/acknowledge memory port.

Software sets up the block through a small register port. Each of the 8 channels has three registers: flags, remaining count and logical start address. Three shared registers hold the table base, the table limit in bytes, and a sticky error-source vector with one bit per channel. The engine serves one request at a time. It holds `busy` for the whole walk and pulses `done` in its last cycle.

Top module: `dma_xlate_engine`

## Requirements
- R1: At the start of every accepted request, the channel's terminal-count (flags bit 8), memory-error (bit 9) and address-error (bit 10) flags are cleared. Software-written values in these bits do not survive into the result.
- R2: A request is rejected when the channel's enable bit (flags bit 0) is clear, or when the request direction does not agree with the channel's memory-to-device bit (flags bit 1). A request with `req_dev2mem`=1 needs bit 1 = 0; a request with `req_dev2mem`=0 needs bit 1 = 1. On rejection the memory-error flag is set, bit n of the error-source register is set for channel n, no memory request is issued and the count is unchanged. Error-source bits only ever clear on reset.
- R3: When the requested length exceeds the channel's remaining count, only the count's worth of bytes is moved.
- R4: Every data move lies within one 4096-byte logical page. The first move covers 4096 minus the page offset of the start address, and no move runs past the remaining length.
- R5: Before each data move, the engine issues one table read (`mem_is_table`=1, `mem_len`=8) at table base + (logical address / 4096) * 8. The frame is taken from `mem_rdata`, which carries the low word of that entry. A request stays asserted with a stable address until it is acknowledged.
- R6: When the page index is at or above table limit / 8, the walk stops with no table read for that page. The address-error flag is set, terminal count stays clear, and the count drops only by the bytes actually moved.
- R7: Each data move's address is the fetched frame plus the page offset of the logical address. `mem_write` is 1 for device-to-memory requests and 0 otherwise.
- R8: On normal completion the terminal-count flag is set and the transferred length is subtracted from the channel count. The channel address register is left unchanged.
- R9: After reset, every channel register, the table base, the table limit and the error-source register read zero.
- R10: `busy` is high from the cycle after a request is accepted until the walk ends. Requests offered while busy are ignored. `done` is high in one cycle and only while busy.
- R11: Register map on `cfg_addr` (6 bits). Bit 5 = 0 selects the channel in bits [4:2], and bits [1:0] pick the register: 0 flags, 1 count, 2 address. Bit 5 = 1 selects a shared register by bits [1:0]: 0 table base, 1 table limit, 2 error source. The error-source register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Transfer request offered |
| req_chan | input | 3 | Channel of the request |
| req_len | input | 32 | Requested byte length |
| req_dev2mem | input | 1 | 1 = device to memory, 0 = memory to device |
| busy | output | 1 | Engine is serving a request |
| done | output | 1 | Last cycle of a request |
| mem_req | output | 1 | Memory request valid |
| mem_addr | output | 32 | Physical byte address of the request |
| mem_len | output | 13 | Bytes in the request |
| mem_is_table | output | 1 | 1 = table entry read, 0 = data move |
| mem_write | output | 1 | Data move writes memory |
| mem_ack | input | 1 | Memory request accepted and completed |
| mem_rdata | input | 32 | Low word of the table entry on a table read |

## Verification
The hardest case to reach is a walk that stops partway through at the table limit, after some bytes have already moved. Reaching it needs a start address just below a page boundary, a limit that admits only the first page, and a count larger than the request. The bench sets up exactly that, then checks the shortened count, the address-error flag and the single pair of memory requests. A second hard point is a request offered while the engine is busy. The bench offers it on a disabled channel, so that a wrongly accepted request would show up as a new error-source bit.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int PAGE_BITS  = 12;
    localparam int ENTRY_BITS = 3;
    localparam int PAGE_BYTES = 1 << PAGE_BITS;
    localparam int SEG_W      = PAGE_BITS + 1;

    localparam int FLG_EN   = 0;
    localparam int FLG_M2D  = 1;
    localparam int FLG_TC   = 8;
    localparam int FLG_MERR = 9;
    localparam int FLG_AERR = 10;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_SEG    = 3'd2,
        ST_FETCH  = 3'd3,
        ST_MOVE   = 3'd4,
        ST_FINISH = 3'd5
    } walk_state_t;

    typedef enum logic [1:0] {
        RG_FLAGS = 2'd0,
        RG_COUNT = 2'd1,
        RG_ADDR  = 2'd2
    } chan_reg_t;

    typedef enum logic [1:0] {
        GR_BASE   = 2'd0,
        GR_LIMIT  = 2'd1,
        GR_ERRSRC = 2'd2
    } glob_reg_t;

    typedef struct packed {
        logic [DATA_W-1:0] flags;
        logic [DATA_W-1:0] count;
        logic [ADDR_W-1:0] addr;
    } chan_regs_t;

    function automatic logic [DATA_W-1:0] drop_status(input logic [DATA_W-1:0] f);
        logic [DATA_W-1:0] r;
        r = f;
        r[FLG_TC]   = 1'b0;
        r[FLG_MERR] = 1'b0;
        r[FLG_AERR] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/dxe_regbank.sv
module dxe_regbank
    import dxe_pkg::*;
#(
    parameter int N_CHAN = 8,
    localparam int CH_W   = $clog2(N_CHAN),
    localparam int CFG_AW = CH_W + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [CH_W-1:0]      rd_chan,
    output chan_regs_t           rd_regs,
    output logic [ADDR_W-1:0]    tbl_base,
    output logic [DATA_W-1:0]    tbl_limit,
    input  logic [CH_W-1:0]      upd_chan,
    input  logic                 upd_flags_we,
    input  logic [DATA_W-1:0]    upd_flags,
    input  logic                 upd_count_we,
    input  logic [DATA_W-1:0]    upd_count,
    input  logic [N_CHAN-1:0]    err_set
);

    chan_regs_t          regs_q [N_CHAN];
    logic [N_CHAN-1:0]   err_q;
    logic                glob_sel;
    logic [CH_W-1:0]     cfg_chan;

    assign glob_sel = cfg_addr[CFG_AW-1];
    assign cfg_chan = cfg_addr[CH_W+1:2];

    for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[c] <= '0;
            end else begin
                if (cfg_we && !glob_sel && cfg_chan == CH_W'(c)) begin
                    case (chan_reg_t'(cfg_addr[1:0]))
                        RG_FLAGS: regs_q[c].flags <= cfg_wdata;
                        RG_COUNT: regs_q[c].count <= cfg_wdata;
                        RG_ADDR:  regs_q[c].addr  <= cfg_wdata;
                        default:  ;
                    endcase
                end
                // engine updates win over a same-cycle software write
                if (upd_flags_we && upd_chan == CH_W'(c))
                    regs_q[c].flags <= upd_flags;
                if (upd_count_we && upd_chan == CH_W'(c))
                    regs_q[c].count <= upd_count;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_base  <= '0;
            tbl_limit <= '0;
            err_q     <= '0;
        end else begin
            if (cfg_we && glob_sel) begin
                case (glob_reg_t'(cfg_addr[1:0]))
                    GR_BASE:  tbl_base  <= cfg_wdata;
                    GR_LIMIT: tbl_limit <= cfg_wdata;
                    default:  ;
                endcase
            end
            err_q <= err_q | err_set;
        end
    end

    assign rd_regs = regs_q[rd_chan];

    always_comb begin
        cfg_rdata = '0;
        if (glob_sel) begin
            case (glob_reg_t'(cfg_addr[1:0]))
                GR_BASE:   cfg_rdata = tbl_base;
                GR_LIMIT:  cfg_rdata = tbl_limit;
                GR_ERRSRC: cfg_rdata = DATA_W'(err_q);
                default:   cfg_rdata = '0;
            endcase
        end else begin
            case (chan_reg_t'(cfg_addr[1:0]))
                RG_FLAGS: cfg_rdata = regs_q[cfg_chan].flags;
                RG_COUNT: cfg_rdata = regs_q[cfg_chan].count;
                RG_ADDR:  cfg_rdata = regs_q[cfg_chan].addr;
                default:  cfg_rdata = '0;
            endcase
        end
    end

    AST_ERRSRC_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((err_q & $past(err_q)) == $past(err_q))) else $error("error source bit cleared"); // R2

    AST_COUNT_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        upd_count_we |-> (upd_count <= regs_q[upd_chan].count)) else $error("count grew"); // R8

endmodule

// File: rtl/dxe_walker.sv
module dxe_walker
    import dxe_pkg::*;
#(
    parameter int N_CHAN = 8,
    localparam int CH_W  = $clog2(N_CHAN),
    localparam int IDX_W = ADDR_W - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [CH_W-1:0]      req_chan,
    input  logic [DATA_W-1:0]    req_len,
    input  logic                 req_dev2mem,
    output logic                 busy,
    output logic                 done,
    output logic [CH_W-1:0]      rd_chan,
    input  chan_regs_t           rd_regs,
    input  logic [ADDR_W-1:0]    tbl_base,
    input  logic [DATA_W-1:0]    tbl_limit,
    output logic [CH_W-1:0]      upd_chan,
    output logic                 upd_flags_we,
    output logic [DATA_W-1:0]    upd_flags,
    output logic                 upd_count_we,
    output logic [DATA_W-1:0]    upd_count,
    output logic [N_CHAN-1:0]    err_set,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [SEG_W-1:0]     mem_len,
    output logic                 mem_is_table,
    output logic                 mem_write,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata
);

    walk_state_t         st_q;
    logic [CH_W-1:0]     chan_q;
    logic                dev2mem_q;
    logic [DATA_W-1:0]   len_q;
    logic [DATA_W-1:0]   flg_q;
    logic [DATA_W-1:0]   cnt_q;
    logic [ADDR_W-1:0]   laddr_q;
    logic [DATA_W-1:0]   remain_q;
    logic [DATA_W-1:0]   moved_q;
    logic [SEG_W-1:0]    seg_q;
    logic [ADDR_W-1:0]   frame_q;
    logic                aerr_q;

    // per-cycle derived values
    logic [PAGE_BITS-1:0] page_off;
    logic [IDX_W-1:0]     page_idx;
    logic [DATA_W-1:0]    n_entries;
    logic                 idx_ok;
    logic [SEG_W-1:0]     room;
    logic [SEG_W-1:0]     seg_cur;
    logic [DATA_W-1:0]    clr_flags;
    logic                 reject;
    logic [DATA_W-1:0]    clamp_len;

    assign page_off  = laddr_q[PAGE_BITS-1:0];
    assign page_idx  = laddr_q[ADDR_W-1:PAGE_BITS];
    assign n_entries = tbl_limit >> ENTRY_BITS;
    assign idx_ok    = DATA_W'(page_idx) < n_entries;
    assign room      = SEG_W'(PAGE_BYTES) - {1'b0, page_off};
    assign seg_cur   = (remain_q < DATA_W'(room)) ? remain_q[SEG_W-1:0] : room;

    assign clr_flags = drop_status(rd_regs.flags);
    assign reject    = !clr_flags[FLG_EN] || (dev2mem_q == clr_flags[FLG_M2D]);
    assign clamp_len = (len_q > rd_regs.count) ? rd_regs.count : len_q;

    assign busy    = (st_q != ST_IDLE);
    assign done    = (st_q == ST_FINISH) || (st_q == ST_CHECK && reject);
    assign rd_chan = busy ? chan_q : req_chan;
    assign upd_chan = chan_q;

    always_comb begin
        upd_flags_we = 1'b0;
        upd_flags    = flg_q;
        upd_count_we = 1'b0;
        upd_count    = cnt_q - moved_q;
        err_set      = '0;
        if (st_q == ST_CHECK) begin
            upd_flags_we = 1'b1;
            upd_flags    = clr_flags;
            if (reject) begin
                upd_flags[FLG_MERR] = 1'b1;
                err_set[chan_q]     = 1'b1;
            end
        end else if (st_q == ST_FINISH) begin
            upd_flags_we = 1'b1;
            upd_count_we = 1'b1;
            if (aerr_q) upd_flags[FLG_AERR] = 1'b1;
            else        upd_flags[FLG_TC]   = 1'b1;
        end
    end

    always_comb begin
        mem_req      = 1'b0;
        mem_is_table = 1'b0;
        mem_write    = 1'b0;
        mem_addr     = '0;
        mem_len      = '0;
        if (st_q == ST_FETCH) begin
            mem_req      = 1'b1;
            mem_is_table = 1'b1;
            mem_addr     = tbl_base + (ADDR_W'(page_idx) << ENTRY_BITS);
            mem_len      = SEG_W'(1 << ENTRY_BITS);
        end else if (st_q == ST_MOVE) begin
            mem_req   = 1'b1;
            mem_write = dev2mem_q;
            mem_addr  = frame_q + ADDR_W'(page_off);
            mem_len   = seg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            chan_q    <= '0;
            dev2mem_q <= 1'b0;
            len_q     <= '0;
            flg_q     <= '0;
            cnt_q     <= '0;
            laddr_q   <= '0;
            remain_q  <= '0;
            moved_q   <= '0;
            seg_q     <= '0;
            frame_q   <= '0;
            aerr_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        chan_q    <= req_chan;
                        dev2mem_q <= req_dev2mem;
                        len_q     <= req_len;
                        st_q      <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    flg_q    <= clr_flags;
                    cnt_q    <= rd_regs.count;
                    laddr_q  <= rd_regs.addr;
                    remain_q <= clamp_len;
                    moved_q  <= '0;
                    aerr_q   <= 1'b0;
                    st_q     <= reject ? ST_IDLE : ST_SEG;
                end
                ST_SEG: begin
                    if (remain_q == '0) begin
                        st_q <= ST_FINISH;
                    end else if (!idx_ok) begin
                        aerr_q <= 1'b1;
                        st_q   <= ST_FINISH;
                    end else begin
                        seg_q <= seg_cur;
                        st_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        frame_q <= mem_rdata;
                        st_q    <= ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (mem_ack) begin
                        laddr_q  <= laddr_q + ADDR_W'(seg_q);
                        remain_q <= remain_q - DATA_W'(seg_q);
                        moved_q  <= moved_q + DATA_W'(seg_q);
                        st_q     <= ST_SEG;
                    end
                end
                ST_FINISH: st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    AST_SEG_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MOVE) |-> ((14'(page_off) + 14'(seg_q)) <= 14'(PAGE_BYTES))) else $error("segment crosses page"); // R4

    AST_SEG_IN_REMAIN: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MOVE) |-> (seg_q != '0 && DATA_W'(seg_q) <= remain_q)) else $error("segment past remaining length"); // R4

    AST_FETCH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_is_table) |-> idx_ok) else $error("table read beyond limit"); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_is_table))) else $error("request dropped before ack"); // R5

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy) else $error("done outside busy"); // R10

    AST_NO_MEM_ON_REJECT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CHECK && reject) |=> !mem_req) else $error("memory access after reject"); // R2

endmodule

// File: rtl/dma_xlate_engine.sv
module dma_xlate_engine
    import dxe_pkg::*;
#(
    parameter int N_CHAN = 8,
    localparam int CH_W   = $clog2(N_CHAN),
    localparam int CFG_AW = CH_W + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 req_valid,
    input  logic [CH_W-1:0]      req_chan,
    input  logic [DATA_W-1:0]    req_len,
    input  logic                 req_dev2mem,
    output logic                 busy,
    output logic                 done,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [SEG_W-1:0]     mem_len,
    output logic                 mem_is_table,
    output logic                 mem_write,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata
);

    logic [CH_W-1:0]    rd_chan;
    chan_regs_t         rd_regs;
    logic [ADDR_W-1:0]  tbl_base;
    logic [DATA_W-1:0]  tbl_limit;
    logic [CH_W-1:0]    upd_chan;
    logic               upd_flags_we;
    logic [DATA_W-1:0]  upd_flags;
    logic               upd_count_we;
    logic [DATA_W-1:0]  upd_count;
    logic [N_CHAN-1:0]  err_set;

    dxe_regbank #(.N_CHAN(N_CHAN)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .rd_chan      (rd_chan),
        .rd_regs      (rd_regs),
        .tbl_base     (tbl_base),
        .tbl_limit    (tbl_limit),
        .upd_chan     (upd_chan),
        .upd_flags_we (upd_flags_we),
        .upd_flags    (upd_flags),
        .upd_count_we (upd_count_we),
        .upd_count    (upd_count),
        .err_set      (err_set)
    );

    dxe_walker #(.N_CHAN(N_CHAN)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_chan     (req_chan),
        .req_len      (req_len),
        .req_dev2mem  (req_dev2mem),
        .busy         (busy),
        .done         (done),
        .rd_chan      (rd_chan),
        .rd_regs      (rd_regs),
        .tbl_base     (tbl_base),
        .tbl_limit    (tbl_limit),
        .upd_chan     (upd_chan),
        .upd_flags_we (upd_flags_we),
        .upd_flags    (upd_flags),
        .upd_count_we (upd_count_we),
        .upd_count    (upd_count),
        .err_set      (err_set),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_len      (mem_len),
        .mem_is_table (mem_is_table),
        .mem_write    (mem_write),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata)
    );

endmodule

// File: tb/sim_dma_xlate_engine.sv
`timescale 1ns/1ps
module sim_dma_xlate_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_chan = '0;
    logic [31:0] req_len = '0;
    logic        req_dev2mem = 1'b0;
    logic        busy, done;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [12:0] mem_len;
    logic        mem_is_table, mem_write;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [31:0] model_base = '0;
    logic [31:0] log_addr [64];
    logic [12:0] log_len  [64];
    logic        log_tbl  [64];
    logic        log_wr   [64];
    int          n_log = 0;

    dma_xlate_engine u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_chan(req_chan), .req_len(req_len), .req_dev2mem(req_dev2mem),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_is_table(mem_is_table), .mem_write(mem_write),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] frame_of(input logic [31:0] idx);
        return 32'h0040_0020 + idx * 32'h2000;
    endfunction

    // memory responder: one-cycle acknowledge, logs every completed request
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= frame_of((mem_addr - model_base) >> 3);
        end else begin
            mem_ack <= 1'b0;
        end
        if (mem_req && mem_ack && n_log < 64) begin
            log_addr[n_log] <= mem_addr;
            log_len[n_log]  <= mem_len;
            log_tbl[n_log]  <= mem_is_table;
            log_wr[n_log]   <= mem_write;
            n_log <= n_log + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 6'h20) model_base = d;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [5:0] ca(input int ch, input int r);
        return 6'((ch << 2) | r);
    endfunction

    task automatic setup_chan(input int ch, input logic [31:0] fl,
                              input logic [31:0] cnt, input logic [31:0] ad);
        wr(ca(ch, 0), fl);
        wr(ca(ch, 1), cnt);
        wr(ca(ch, 2), ad);
    endtask

    task automatic run_req(input int ch, input logic [31:0] len, input logic d2m,
                           input string tag, input bit poke_busy);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 3'(ch); req_len = len; req_dev2mem = d2m;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 busy after accept"}, 32'(busy), 32'd1);
        if (poke_busy) begin
            req_valid = 1'b1; req_chan = 3'd7; req_len = 32'h10; req_dev2mem = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    task automatic chk_log(input string tag, input int k, input logic [31:0] a,
                           input logic [12:0] l, input logic t, input logic w);
        chk({tag, " addr"}, log_addr[k], a);
        chk({tag, " len"},  32'(log_len[k]), 32'(l));
        chk({tag, " kind"}, {30'd0, log_tbl[k], log_wr[k]}, {30'd0, t, w});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int ch = 0; ch < 8; ch++) begin
            for (int r = 0; r < 3; r++) begin
                rd(ca(ch, r), v);
                chk("R9 channel reg after reset", v, 32'h0);
            end
        end
        rd(6'h20, v); chk("R9 table base after reset", v, 32'h0);
        rd(6'h21, v); chk("R9 table limit after reset", v, 32'h0);
        rd(6'h22, v); chk("R9 error source after reset", v, 32'h0);
        chk("R10 idle after reset", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reject_disabled;
        logic [31:0] v;
        int s;
        setup_chan(2, 32'h0000_0000, 32'h100, 32'h1000);
        s = n_log;
        run_req(2, 32'h40, 1'b1, "R2 disabled", 1'b0);
        rd(ca(2, 0), v); chk("R2 disabled sets memory error", v, 32'h0000_0200);
        rd(ca(2, 1), v); chk("R2 disabled keeps count", v, 32'h100);
        rd(6'h22, v);    chk("R2 disabled error source bit", v, 32'h04);
        chk("R2 disabled no memory traffic", 32'(n_log - s), 32'd0);
    endtask

    task automatic t_reject_direction;
        logic [31:0] v;
        setup_chan(5, 32'h0000_0103, 32'h100, 32'h0);
        run_req(5, 32'h40, 1'b1, "R2 direction", 1'b0);
        rd(ca(5, 0), v); chk("R2 R1 mismatch flags", v, 32'h0000_0203);
        rd(6'h22, v);    chk("R2 mismatch error source accumulates", v, 32'h24);
        wr(6'h22, 32'h0);
        rd(6'h22, v);    chk("R11 error source ignores writes", v, 32'h24);
    endtask

    task automatic t_cross_page;
        logic [31:0] v;
        int s;
        wr(6'h20, 32'h0000_8000);
        wr(6'h21, 32'd128);
        setup_chan(1, 32'h0000_0701, 32'h300, 32'h0000_1F00);
        s = n_log;
        run_req(1, 32'h200, 1'b1, "R4 cross", 1'b0);
        chk("R4 cross request count", 32'(n_log - s), 32'd4);
        chk_log("R5 cross table 0", s + 0, 32'h8008, 13'd8, 1'b1, 1'b0);
        chk_log("R7 cross data 0",  s + 1, frame_of(1) + 32'hF00, 13'h100, 1'b0, 1'b1);
        chk_log("R5 cross table 1", s + 2, 32'h8010, 13'd8, 1'b1, 1'b0);
        chk_log("R4 cross data 1",  s + 3, frame_of(2), 13'h100, 1'b0, 1'b1);
        rd(ca(1, 0), v); chk("R1 R8 cross flags", v, 32'h0000_0101);
        rd(ca(1, 1), v); chk("R8 cross count", v, 32'h100);
        rd(ca(1, 2), v); chk("R8 R11 cross address kept", v, 32'h0000_1F00);
    endtask

    task automatic t_clamp;
        logic [31:0] v;
        int s;
        setup_chan(3, 32'h0000_0001, 32'h50, 32'h0000_3000);
        s = n_log;
        run_req(3, 32'h1000, 1'b1, "R3 clamp", 1'b0);
        chk("R3 clamp request count", 32'(n_log - s), 32'd2);
        chk_log("R3 clamp data", s + 1, frame_of(3), 13'h50, 1'b0, 1'b1);
        rd(ca(3, 1), v); chk("R3 clamp count", v, 32'h0);
        rd(ca(3, 0), v); chk("R8 clamp flags", v, 32'h0000_0101);
    endtask

    task automatic t_limit;
        logic [31:0] v;
        int s;
        wr(6'h21, 32'd32);
        setup_chan(4, 32'h0000_0001, 32'h1000, 32'h0000_3F80);
        s = n_log;
        run_req(4, 32'h200, 1'b1, "R6 limit", 1'b0);
        chk("R6 limit request count", 32'(n_log - s), 32'd2);
        chk_log("R6 limit table", s + 0, 32'h8018, 13'd8, 1'b1, 1'b0);
        chk_log("R6 limit data",  s + 1, frame_of(3) + 32'hF80, 13'h80, 1'b0, 1'b1);
        rd(ca(4, 0), v); chk("R6 limit flags", v, 32'h0000_0401);
        rd(ca(4, 1), v); chk("R6 limit count", v, 32'h0F80);
        wr(6'h21, 32'd128);
    endtask

    task automatic t_multi_read;
        logic [31:0] v;
        int s;
        setup_chan(6, 32'h0000_0003, 32'h3000, 32'h0000_0010);
        s = n_log;
        run_req(6, 32'h2000, 1'b0, "R7 multi", 1'b1);
        chk("R4 multi request count", 32'(n_log - s), 32'd6);
        chk_log("R4 multi data 0", s + 1, frame_of(0) + 32'h10, 13'hFF0, 1'b0, 1'b0);
        chk_log("R5 multi table 1", s + 2, 32'h8008, 13'd8, 1'b1, 1'b0);
        chk_log("R4 multi data 1", s + 3, frame_of(1), 13'h1000, 1'b0, 1'b0);
        chk_log("R4 multi data 2", s + 5, frame_of(2), 13'h10, 1'b0, 1'b0);
        rd(ca(6, 0), v); chk("R8 multi flags", v, 32'h0000_0103);
        rd(ca(6, 1), v); chk("R8 multi count", v, 32'h1000);
        rd(6'h22, v);    chk("R10 request while busy ignored", v, 32'h24);
        rd(ca(7, 0), v); chk("R10 busy-time channel untouched", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reject_disabled();
        t_reject_direction();
        t_cross_page();
        t_clamp();
        t_limit();
        t_multi_read();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule